// File: doc/BRIEF.md
# Vector Bit-Mask Generator

This unit turns an instruction immediate into a 128-bit vector constant. It has two modes. In byte mode, every bit of a 16-bit immediate selects one result byte, which is either all ones or all zeros. In range mode, two bit positions mark the first and last bit of a contiguous run inside one element, and that element pattern is copied across the whole vector. The element size is selected by a size code. Bit positions count from the most significant bit of the element. When the first position lies beyond the last, the run wraps around the end of the element.

A request is a one-cycle start pulse that carries the mode and the immediates. One clock later the unit shows either the new vector with a one-cycle valid pulse, or a one-cycle exception pulse for an illegal size code. In the exception case the vector output is left untouched. Register-file writeback and instruction decoding belong to the surrounding pipeline.

Top module: `vmask_gen`

## Requirements
- R1: In byte mode (mode_i = 0), immediate bit k (k = 0..15) fills result bits [8k+7:8k] with ones when set and with zeros when clear. The upper eight immediate bits therefore cover result bits 127:64.
- R2: Size codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. A range-mode start with a code of 4 to 7 raises exc_o for exactly one cycle and does not raise valid_o.
- R3: While exc_o is high, result_o keeps the value it held before the illegal request.
- R4: In range mode (mode_i = 1), the first and last positions are taken modulo the element width before they are used.
- R5: Position p refers to element bit (width-1-p), so position 0 is the element's most significant bit.
- R6: When first <= last (after reduction), exactly positions first through last, inclusive, are set.
- R7: When first > last, positions first through width-1 and positions 0 through last are set.
- R8: The element mask is repeated in every element of the 128-bit result.
- R9: result_o and valid_o update on the clock edge that samples start_i high. valid_o is high for exactly one cycle per start. Without a start, neither valid_o nor exc_o rises and result_o does not change.
- R10: After reset, result_o is zero and valid_o and exc_o are low.
- R11: Byte mode ignores the size code: even codes 4 to 7 give a valid result and no exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle per request |
| mode_i | input | 1 | 0 = byte mode, 1 = range mode |
| imm_bytes_i | input | 16 | Byte-select immediate for byte mode |
| pos_first_i | input | 8 | First bit position of the run (range mode) |
| pos_last_i | input | 8 | Last bit position of the run (range mode) |
| esize_i | input | 3 | Element size code (range mode) |
| result_o | output | 128 | Generated vector |
| valid_o | output | 1 | One-cycle pulse when result_o holds a new vector |
| exc_o | output | 1 | One-cycle pulse for an illegal size code |

## Verification
Byte mode is tried with all bytes set, with only the two outer bytes set, and with an irregular pattern in the lower half under an illegal size code. Together these show the lane order, the split between the two halves, and that byte mode ignores the size code. Range mode is tried at all four element sizes with runs that do not wrap, runs that wrap, single-bit runs at both ends, and positions above the element width. These cases separate wrong bit numbering, a missing modulo step, a missing wrap, and wrong replication. Directed cases then cover illegal size codes, idle cycles with inputs changing, and back-to-back starts.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
    localparam int VEC_W       = 128;
    localparam int NUM_SIZES   = 4;
    localparam int SIZE_CODE_W = 3;
    localparam int SEL_W       = $clog2(NUM_SIZES);
    localparam int POS_W       = 8;
    localparam int IMM_W       = VEC_W / 8;
    localparam int BASE_ELEM_W = 8;

    typedef enum logic {
        MODE_BYTES = 1'b0,
        MODE_RANGE = 1'b1
    } mode_e;

    typedef struct packed {
        logic [VEC_W-1:0] result;
        logic             valid;
        logic             exc;
    } gen_state_t;
endpackage

// File: rtl/vmask_bytes.sv
module vmask_bytes #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W/8-1:0] lane_sel_i,
    output logic [VEC_W-1:0]   mask_o
);
    localparam int LANES = VEC_W / 8;

    // one select bit per byte lane, lane 0 is the least significant byte
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign mask_o[lane*8 +: 8] = {8{lane_sel_i[lane]}};
    end
endmodule

// File: rtl/vmask_range.sv
module vmask_range #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8,
    parameter int POS_W  = 8
) (
    input  logic [POS_W-1:0] first_i,
    input  logic [POS_W-1:0] last_i,
    output logic [VEC_W-1:0] mask_o
);
    localparam int IDX_W  = $clog2(ELEM_W);
    localparam int COPIES = VEC_W / ELEM_W;

    logic [IDX_W-1:0]  first_m;
    logic [IDX_W-1:0]  last_m;
    logic              no_wrap;
    logic [ELEM_W-1:0] elem;

    // element width is a power of two, so the modulo is a truncation
    assign first_m = first_i[IDX_W-1:0];
    assign last_m  = last_i[IDX_W-1:0];
    assign no_wrap = (first_m <= last_m);

    always_comb begin
        elem = '0;
        for (int p = 0; p < ELEM_W; p++) begin
            // position p counts from the element's most significant bit
            if (no_wrap) begin
                elem[ELEM_W-1-p] = (p >= int'(first_m)) && (p <= int'(last_m));
            end else begin
                elem[ELEM_W-1-p] = (p >= int'(first_m)) || (p <= int'(last_m));
            end
        end
    end

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign mask_o[c*ELEM_W +: ELEM_W] = elem;
    end
endmodule

// File: rtl/vmask_gen.sv
module vmask_gen
    import vmask_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   mode_i,
    input  logic [IMM_W-1:0]       imm_bytes_i,
    input  logic [POS_W-1:0]       pos_first_i,
    input  logic [POS_W-1:0]       pos_last_i,
    input  logic [SIZE_CODE_W-1:0] esize_i,
    output logic [VEC_W-1:0]       result_o,
    output logic                   valid_o,
    output logic                   exc_o
);
    logic [VEC_W-1:0] byte_mask;
    logic [VEC_W-1:0] range_mask [NUM_SIZES];
    logic [VEC_W-1:0] range_sel;
    logic             size_ok;
    mode_e            mode;
    gen_state_t       state_d;
    gen_state_t       state_q;

    vmask_bytes #(
        .VEC_W(VEC_W)
    ) u_bytes (
        .lane_sel_i(imm_bytes_i),
        .mask_o    (byte_mask)
    );

    // one range builder per legal element size, widths doubling from the base
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vmask_range #(
            .VEC_W (VEC_W),
            .ELEM_W(BASE_ELEM_W << s),
            .POS_W (POS_W)
        ) u_range (
            .first_i(pos_first_i),
            .last_i (pos_last_i),
            .mask_o (range_mask[s])
        );
    end

    assign mode      = mode_e'(mode_i);
    assign size_ok   = (esize_i < SIZE_CODE_W'(NUM_SIZES));
    assign range_sel = range_mask[esize_i[SEL_W-1:0]];

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        state_d.exc   = 1'b0;
        if (start_i) begin
            if (mode == MODE_RANGE && !size_ok) begin
                state_d.exc = 1'b1;
            end else begin
                state_d.valid  = 1'b1;
                state_d.result = (mode == MODE_BYTES) ? byte_mask : range_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign valid_o  = state_q.valid;
    assign exc_o    = state_q.exc;
endmodule

// File: rtl/vmask_gen_chk.sv
module vmask_gen_chk
    import vmask_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   mode_i,
    input logic [IMM_W-1:0]       imm_bytes_i,
    input logic [POS_W-1:0]       pos_first_i,
    input logic [POS_W-1:0]       pos_last_i,
    input logic [SIZE_CODE_W-1:0] esize_i,
    input logic [VEC_W-1:0]       result_o,
    input logic                   valid_o,
    input logic                   exc_o
);
    assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, exc_o}));

    assert_exc_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> ($past(start_i) && $past(mode_i)
                   && ($past(esize_i) >= SIZE_CODE_W'(NUM_SIZES))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> $stable(result_o));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!valid_o && !exc_o && $stable(result_o)));

    assert_bytes_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i) |=> (valid_o && !exc_o));
endmodule

bind vmask_gen vmask_gen_chk u_chk (.*);

// File: tb/vmask_gen_test.sv
`timescale 1ns/1ps
module vmask_gen_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [15:0]  imm_bytes_i = '0;
    logic [7:0]   pos_first_i = '0;
    logic [7:0]   pos_last_i = '0;
    logic [2:0]   esize_i = '0;
    logic [127:0] result_o;
    logic         valid_o;
    logic         exc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vmask_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .imm_bytes_i(imm_bytes_i),
        .pos_first_i(pos_first_i),
        .pos_last_i (pos_last_i),
        .esize_i    (esize_i),
        .result_o   (result_o),
        .valid_o    (valid_o),
        .exc_o      (exc_o)
    );

    // {mode, size code, first, last, byte immediate, expected result}
    localparam int NV = 12;
    localparam logic [163:0] VECS [NV] = '{
        {1'b0, 3'd0, 8'd0,  8'd0,  16'hFFFF, {16{8'hFF}}},                  // R1
        {1'b0, 3'd0, 8'd0,  8'd0,  16'h8001, 128'hFF00_0000_0000_0000_0000_0000_0000_00FF}, // R1
        {1'b0, 3'd5, 8'd3,  8'd1,  16'h00A5, {64'h0, 64'hFF00_FF00_00FF_00FF}}, // R1 R11
        {1'b1, 3'd0, 8'd0,  8'd7,  16'h0000, {16{8'hFF}}},                  // R6 R8
        {1'b1, 3'd0, 8'd2,  8'd4,  16'h0000, {16{8'h38}}},                  // R5 R6 R8
        {1'b1, 3'd0, 8'd6,  8'd1,  16'h0000, {16{8'hC3}}},                  // R7 R8
        {1'b1, 3'd1, 8'd0,  8'd0,  16'h0000, {8{16'h8000}}},                // R5 R2
        {1'b1, 3'd2, 8'd30, 8'd33, 16'h0000, {4{32'hC000_0003}}},           // R4 R7
        {1'b1, 3'd3, 8'd63, 8'd63, 16'h0000, {2{64'h1}}},                   // R5 R2
        {1'b1, 3'd3, 8'd68, 8'd5,  16'h0000, {2{64'h0C00_0000_0000_0000}}}, // R4 R6
        {1'b1, 3'd1, 8'd5,  8'd21, 16'h0000, {8{16'h0400}}},                // R4
        {1'b1, 3'd2, 8'd4,  8'd11, 16'h0000, {4{32'h0FF0_0000}}}            // R6 R8
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic m, input logic [2:0] es, input logic [7:0] f,
                         input logic [7:0] l, input logic [15:0] imm);
        @(negedge clk);
        mode_i = m; esize_i = es; pos_first_i = f; pos_last_i = l; imm_bytes_i = imm;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [127:0] prev;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 result", result_o, '0);
        check("R10 valid", {127'b0, valid_o}, 128'd0);
        check("R10 exc", {127'b0, exc_o}, 128'd0);
        rst_n = 1'b1;

        // table walk: R1 R4 R5 R6 R7 R8 R11, latency R9
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i][163], VECS[i][162:160], VECS[i][159:152],
                  VECS[i][151:144], VECS[i][143:128]);
            check($sformatf("R9 valid entry %0d", i), {127'b0, valid_o}, 128'd1);
            check($sformatf("R1/R4/R6/R7/R8 result entry %0d", i), result_o, VECS[i][127:0]);
            check($sformatf("R11 no exc entry %0d", i), {127'b0, exc_o}, 128'd0);
        end
        prev = VECS[NV-1][127:0];

        // R9: valid lasts one cycle
        @(negedge clk);
        check("R9 single-cycle valid", {127'b0, valid_o}, 128'd0);

        // R2 R3: illegal size codes in range mode
        issue(1'b1, 3'd4, 8'd1, 8'd2, 16'h0);
        check("R2 exc raised code 4", {127'b0, exc_o}, 128'd1);
        check("R2 no valid on exc", {127'b0, valid_o}, 128'd0);
        check("R3 result held", result_o, prev);
        @(negedge clk);
        check("R2 exc one cycle", {127'b0, exc_o}, 128'd0);
        issue(1'b1, 3'd7, 8'd0, 8'd7, 16'h0);
        check("R2 exc raised code 7", {127'b0, exc_o}, 128'd1);
        check("R3 result held code 7", result_o, prev);

        // R9: inputs change without start
        @(negedge clk);
        mode_i = 1'b0; imm_bytes_i = 16'h1234; esize_i = 3'd0;
        repeat (2) @(negedge clk);
        check("R9 idle no valid", {127'b0, valid_o}, 128'd0);
        check("R9 idle result unchanged", result_o, prev);

        // R9: back-to-back starts
        @(negedge clk);
        mode_i = 1'b0; imm_bytes_i = 16'h0100; start_i = 1'b1;
        @(negedge clk);
        check("R9 first of pair", result_o, {56'h0, 8'hFF, 64'h0});
        check("R9 first valid", {127'b0, valid_o}, 128'd1);
        mode_i = 1'b1; esize_i = 3'd3; pos_first_i = 8'd0; pos_last_i = 8'd3;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 second of pair", result_o, {2{64'hF000_0000_0000_0000}});
        check("R9 second valid", {127'b0, valid_o}, 128'd1);
        @(negedge clk);
        check("R9 valid drops", {127'b0, valid_o}, 128'd0);

        finish_run();
    end
endmodule